// File: doc/BRIEF.md
# Pipelined Byte-Lane Synchronous Memory

A single-port, clocked storage block with four byte lanes, each made of eight data bits and one parity bit. The address, write data and every write control are captured at the rising clock edge. A read comes back through an output register, so the first word of a burst arrives two edges after its request and each further back-to-back request yields one word per clock. Writes go through a one-entry write buffer. A read issued in the cycle right after a write to the same word sees the freshly written lanes, because they are forwarded lane by lane from the buffer.

Writes are selected by a two-level decode. A global write strobe stores the whole word. Otherwise a byte-write enable opens the four per-lane strobes, and each strobe governs exactly one data byte and its parity bit. An output enable acts without the clock on the pad-driver enable. A sleep input parks the block, but it is only accepted in a cycle with the chip deselected. Leaving sleep is followed by a short recovery during which requests are dropped.

Top module: `memTop`

## Requirements
- R1: While reset is held and after its release with no access, `busDrive` is 0 and `dataOut`/`parOut` are all zeros.
- R2: A selected cycle with `globalWrN`=0 writes all four lanes, whatever `byteWrEnN` and `laneWrN` are.
- R3: With `globalWrN`=1 and `byteWrEnN`=1 the lane strobes are ignored and a selected cycle is a read that leaves memory unchanged.
- R4: With `globalWrN`=1 and `byteWrEnN`=0, a 0 on `laneWrN[i]` writes `dataIn[8i+7:8i]` and `parIn[i]` only. Lanes whose strobe is 1 keep their old contents.
- R5: A cycle with `chipSelN`=1 performs no access. Write controls in that cycle are ignored, and two edges later the bus is released.
- R6: A read sampled at edge k drives the stored word on `dataOut`/`parOut` with `busDrive`=1 between edges k+1 and k+2. Back-to-back reads deliver one word per clock.
- R7: A read in the cycle directly after a write to the same address returns the merged word, with new data in the written lanes and old data elsewhere.
- R8: `outEnN`=1 forces `busDrive` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the pending read data.
- R9: Sleep is entered only at an edge where `sleep`=1 and `chipSelN`=1. If `chipSelN`=0 at that edge, the access proceeds normally. While asleep, requests are ignored and `busDrive` is 0.
- R10: Accesses are ignored in the first cycle with `sleep` sampled 0 and in the 2 cycles that follow it, and the bus stays released meanwhile. The next cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| chipSelN | input | 1 | Active-low select; high makes the cycle idle |
| globalWrN | input | 1 | Active-low whole-word write |
| byteWrEnN | input | 1 | Active-low enable for the lane strobes |
| laneWrN | input | LANES | Active-low per-lane write strobes |
| outEnN | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Power-down request, accepted only when deselected |
| addr | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data, lane i in bits [8i+7:8i] |
| parIn | input | LANES | Write parity, bit i belongs to lane i |
| dataOut | output | LANES*LANE_W | Read data, zero when the bus is released |
| parOut | output | LANES | Read parity, zero when the bus is released |
| busDrive | output | 1 | Pad driver enable; 0 means high impedance |

## Verification
The bench fills every word with full-word writes and reads all of them back. This separates address decoding from lane handling. All sixteen lane-strobe patterns are then applied on separate words, so a swapped, missing or inverted lane strobe shows up as a wrong byte or parity bit. The pass-through pattern pairs a partial write with the immediate read of the same word, which catches forwarding that ignores lanes or forwarding that is missing altogether. The sleep and recovery sequence tries writes in each blocked cycle and in the first open cycle, so an off-by-one in the recovery count changes which words hold new data.

// File: rtl/memPkg.sv
package memPkg;

  localparam int RECOVER_CYCLES = 2;

  typedef struct packed {
    logic capture;
    logic busy;
    logic readLoad;
    logic commit;
    logic asleep;
    logic recovering;
  } memStrobes_t;

endpackage

// File: rtl/memCtrl.sv
module memCtrl
  import memPkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSelN,
  input  logic             globalWrN,
  input  logic             byteWrEnN,
  input  logic [LANES-1:0] laneWrN,
  input  logic             outEnN,
  input  logic             sleep,
  output logic [LANES-1:0] laneMask,
  output memStrobes_t      strb,
  output logic             busDrive
);

  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);

  logic             s1Valid;
  logic             s1Write;
  logic             pendValid;
  logic             outValid;
  logic             asleep;
  logic [CNT_W-1:0] recCnt;
  logic             accept;
  logic             isWrite;
  logic             recovering;

  // Two-level write decode: global strobe wins, else lane strobes gated by enable
  always_comb begin
    if (!globalWrN) begin
      laneMask = '1;
    end else if (!byteWrEnN) begin
      laneMask = ~laneWrN;
    end else begin
      laneMask = '0;
    end
  end

  assign isWrite    = |laneMask;
  assign recovering = (recCnt != '0);
  assign accept     = !chipSelN && !asleep && !recovering;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid   <= 1'b0;
      s1Write   <= 1'b0;
      pendValid <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      s1Valid   <= accept;
      s1Write   <= accept && isWrite;
      pendValid <= s1Valid && s1Write;
      outValid  <= s1Valid && !s1Write;
    end
  end

  // Sleep entry only while deselected; a release arms the recovery counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asleep <= 1'b0;
      recCnt <= '0;
    end else begin
      asleep <= sleep && (asleep || chipSelN);
      if (asleep && !sleep) begin
        recCnt <= CNT_W'(RECOVER_CYCLES);
      end else if (recovering) begin
        recCnt <= recCnt - 1'b1;
      end
    end
  end

  assign busDrive = !outEnN && outValid && !asleep && !recovering;

  always_comb begin
    strb.capture    = accept;
    strb.busy       = s1Valid;
    strb.readLoad   = s1Valid && !s1Write;
    strb.commit     = pendValid;
    strb.asleep     = asleep;
    strb.recovering = recovering;
  end

endmodule

// File: rtl/memData.sv
module memData
  import memPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  memStrobes_t             strb,
  input  logic                    busDrive,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic [LANES-1:0]        parIn,
  input  logic [LANES-1:0]        laneMask,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic [LANES-1:0]        parOut
);

  localparam int LANE_BITS = LANE_W + 1;
  localparam int WORD_W    = LANES * LANE_BITS;
  localparam int DEPTH     = 1 << ADDR_W;

  logic [WORD_W-1:0] wordIn;
  logic [ADDR_W-1:0] s1Addr;
  logic [WORD_W-1:0] s1Word;
  logic [LANES-1:0]  s1Mask;
  logic [ADDR_W-1:0] pendAddr;
  logic [WORD_W-1:0] pendWord;
  logic [LANES-1:0]  pendMask;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] fwdWord;
  logic [WORD_W-1:0] outWord;
  logic              fwdHit;
  logic [WORD_W-1:0] mem [DEPTH];

  // Lane i is stored as {parity, data byte}
  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign wordIn[i*LANE_BITS +: LANE_BITS] = {parIn[i], dataIn[i*LANE_W +: LANE_W]};
  end

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      s1Addr <= addr;
      s1Word <= wordIn;
      s1Mask <= laneMask;
    end
  end

  // One-entry write buffer, retired one cycle after capture
  always_ff @(posedge clk) begin
    pendAddr <= s1Addr;
    pendWord <= s1Word;
    pendMask <= s1Mask;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int i = 0; i < LANES; i++) begin
        if (pendMask[i]) begin
          mem[pendAddr][i*LANE_BITS +: LANE_BITS] <= pendWord[i*LANE_BITS +: LANE_BITS];
        end
      end
    end
  end

  assign rdWord = mem[s1Addr];
  assign fwdHit = strb.commit && (pendAddr == s1Addr);

  // Lane-wise forwarding of the word still sitting in the write buffer
  for (genvar i = 0; i < LANES; i++) begin : g_fwd
    assign fwdWord[i*LANE_BITS +: LANE_BITS] = (fwdHit && pendMask[i])
        ? pendWord[i*LANE_BITS +: LANE_BITS]
        : rdWord[i*LANE_BITS +: LANE_BITS];
  end

  always_ff @(posedge clk) begin
    if (strb.readLoad) begin
      outWord <= fwdWord;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign dataOut[i*LANE_W +: LANE_W] = busDrive ? outWord[i*LANE_BITS +: LANE_W] : '0;
    assign parOut[i] = busDrive ? outWord[i*LANE_BITS + LANE_W] : 1'b0;
  end

endmodule

// File: rtl/memTop.sv
module memTop
  import memPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    chipSelN,
  input  logic                    globalWrN,
  input  logic                    byteWrEnN,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    outEnN,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic [LANES-1:0]        parIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic [LANES-1:0]        parOut,
  output logic                    busDrive
);

  memStrobes_t      strb;
  logic [LANES-1:0] laneMask;

  memCtrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .chipSelN  (chipSelN),
    .globalWrN (globalWrN),
    .byteWrEnN (byteWrEnN),
    .laneWrN   (laneWrN),
    .outEnN    (outEnN),
    .sleep     (sleep),
    .laneMask  (laneMask),
    .strb      (strb),
    .busDrive  (busDrive)
  );

  memData #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_data (
    .clk      (clk),
    .strb     (strb),
    .busDrive (busDrive),
    .addr     (addr),
    .dataIn   (dataIn),
    .parIn    (parIn),
    .laneMask (laneMask),
    .dataOut  (dataOut),
    .parOut   (parOut)
  );

endmodule

// File: rtl/memChk.sv
module memChk (
  input logic clk,
  input logic rstN,
  input logic chipSelN,
  input logic outEnN,
  input logic sleep,
  input logic busDrive,
  input logic busy,
  input logic asleep,
  input logic recovering
);

  a_r8_oe_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !busDrive);

  a_r9_entry_needs_deselect: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asleep) |-> $past(chipSelN));

  a_r9_asleep_blocks_access: assert property (@(posedge clk) disable iff (!rstN)
    asleep |=> !busy);

  a_r10_release_starts_recovery: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !sleep) |=> recovering);

  a_r10_recovery_blocks_access: assert property (@(posedge clk) disable iff (!rstN)
    recovering |=> !busy);

  a_r5_deselect_releases_bus: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |-> ##2 !busDrive);

endmodule

bind memTop memChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chipSelN   (chipSelN),
  .outEnN     (outEnN),
  .sleep      (sleep),
  .busDrive   (busDrive),
  .busy       (strb.busy),
  .asleep     (strb.asleep),
  .recovering (strb.recovering)
);

// File: tb/tb_memTop.sv
module tb_memTop;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int LANES      = 4;
  localparam int LANE_W     = 8;
  localparam int DW         = LANES * LANE_W;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              chipSelN, globalWrN, byteWrEnN, outEnN, sleep;
  logic [LANES-1:0]  laneWrN;
  logic [ADDR_W-1:0] addr;
  logic [DW-1:0]     dataIn;
  logic [LANES-1:0]  parIn;
  logic [DW-1:0]     dataOut;
  logic [LANES-1:0]  parOut;
  logic              busDrive;

  logic [DW-1:0]     refD [DEPTH];
  logic [LANES-1:0]  refP [DEPTH];

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memTop #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .globalWrN(globalWrN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN), .outEnN(outEnN), .sleep(sleep),
    .addr(addr), .dataIn(dataIn), .parIn(parIn), .dataOut(dataOut),
    .parOut(parOut), .busDrive(busDrive)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] genData(int a, int salt);
    return DW'(32'h9E3779B9 * (a + 1) + 32'h01010101 * salt);
  endfunction

  task automatic drive(bit cs, bit gw, bit bwe, logic [LANES-1:0] ln,
                       int a, logic [DW-1:0] d, logic [LANES-1:0] p, bit slp);
    @(negedge clk);
    chipSelN = cs; globalWrN = gw; byteWrEnN = bwe; laneWrN = ln;
    addr = ADDR_W'(a); dataIn = d; parIn = p; sleep = slp;
  endtask

  task automatic idle(bit slp);
    drive(1'b1, 1'b1, 1'b1, '1, 0, '0, '0, slp);
  endtask

  task automatic readReq(int a, bit slp);
    drive(1'b0, 1'b1, 1'b1, '1, a, '0, '0, slp);
  endtask

  // Issues a write and updates the reference from the decode rules (R2, R4)
  task automatic writeOp(int a, bit gw, bit bwe, logic [LANES-1:0] ln,
                         logic [DW-1:0] d, logic [LANES-1:0] p);
    logic [LANES-1:0] m;
    drive(1'b0, gw, bwe, ln, a, d, p, 1'b0);
    m = !gw ? '1 : (!bwe ? ~ln : '0);
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        refD[a][i*LANE_W +: LANE_W] = d[i*LANE_W +: LANE_W];
        refP[a][i] = p[i];
      end
    end
  endtask

  task automatic readCheck(int a, string req);
    readReq(a, 1'b0);
    idle(1'b0);
    @(negedge clk);
    chk(req, {27'd0, busDrive, parOut, dataOut}, {27'd0, 1'b1, refP[a], refD[a]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; outEnN = 1'b0;
    chipSelN = 1'b1; globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = '1;
    addr = '0; dataIn = '0; parIn = '0; sleep = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset", {27'd0, busDrive, parOut, dataOut}, 64'd0);
    rstN = 1'b1;
    idle(1'b0); idle(1'b0);
    @(negedge clk);
    chk("R1 after release", {27'd0, busDrive, parOut, dataOut}, 64'd0);

    // R2: full-word fill with global write, lane strobes set to noise
    for (int a = 0; a < DEPTH; a++) begin
      writeOp(a, 1'b0, a[0], LANES'(a), genData(a, 1), LANES'(a * 3));
    end
    for (int a = 0; a < DEPTH; a++) readCheck(a, "R2 fill readback");

    // R2: global write wins over enabled lane strobes that are all off
    writeOp(1, 1'b0, 1'b0, '1, genData(1, 7), 4'hA);
    readCheck(1, "R2 global overrides lanes");

    // R4: every lane pattern on its own word
    for (int m = 0; m < 16; m++) begin
      writeOp(m, 1'b1, 1'b0, ~LANES'(m), genData(m, 9), ~LANES'(m));
    end
    for (int m = 0; m < 16; m++) readCheck(m, "R4 lane mask");

    // R3: strobes without enable make a read; memory unchanged
    drive(1'b0, 1'b1, 1'b1, '0, 2, genData(2, 33), 4'hF, 1'b0);
    idle(1'b0);
    @(negedge clk);
    chk("R3 strobes ignored read", {27'd0, busDrive, parOut, dataOut},
        {27'd0, 1'b1, refP[2], refD[2]});
    readCheck(2, "R3 memory unchanged");

    // R6: back-to-back burst, one word per clock
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) chk("R6 burst beat", {27'd0, busDrive, parOut, dataOut},
                      {27'd0, 1'b1, refP[i-2], refD[i-2]});
      if (i < 4) begin
        chipSelN = 1'b0; globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = '1; addr = ADDR_W'(i);
      end else begin
        chipSelN = 1'b1;
      end
    end

    // R7: pass-through with partial and full masks
    for (int k = 0; k < 4; k++) begin
      writeOp(5 + k, 1'b1, 1'b0, LANES'(4'b1010 >> k), genData(k, 50), LANES'(k + 5));
      readCheck(5 + k, "R7 pass-through merged");
    end
    writeOp(12, 1'b0, 1'b1, '1, genData(12, 60), 4'h3);
    readCheck(12, "R7 pass-through full word");

    // R5: deselected cycle with write controls does nothing
    readReq(2, 1'b0);
    drive(1'b1, 1'b0, 1'b0, '0, 3, genData(3, 77), 4'hF, 1'b0);
    idle(1'b0);
    chk("R5 prior read", {27'd0, busDrive, parOut, dataOut}, {27'd0, 1'b1, refP[2], refD[2]});
    @(negedge clk);
    chk("R5 bus released", {63'd0, busDrive}, 64'd0);
    readCheck(3, "R5 no write when deselected");

    // R8: output enable acts without a clock edge
    readReq(4, 1'b0);
    idle(1'b0);
    @(negedge clk);
    outEnN = 1'b1;
    #1 chk("R8 oe high releases", {63'd0, busDrive}, 64'd0);
    outEnN = 1'b0;
    #1 chk("R8 oe low restores", {27'd0, busDrive, parOut, dataOut},
           {27'd0, 1'b1, refP[4], refD[4]});

    // R9: sleep while selected is not taken
    readReq(6, 1'b1);
    idle(1'b0);
    @(negedge clk);
    chk("R9 no entry while selected", {27'd0, busDrive, parOut, dataOut},
        {27'd0, 1'b1, refP[6], refD[6]});

    // R9: enter sleep, attempts ignored, bus released
    idle(1'b1);
    drive(1'b0, 1'b0, 1'b1, '1, 7, genData(7, 90), 4'hF, 1'b1);
    readReq(7, 1'b1);
    idle(1'b1);
    @(negedge clk);
    chk("R9 asleep bus off", {63'd0, busDrive}, 64'd0);

    // R10: release cycle plus 2 recovery cycles are ignored, then accepted
    drive(1'b0, 1'b0, 1'b1, '1, 8, genData(8, 91), 4'h1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, '1, 9, genData(9, 92), 4'h2, 1'b0);
    chk("R10 recovery bus off", {63'd0, busDrive}, 64'd0);
    drive(1'b0, 1'b0, 1'b1, '1, 10, genData(10, 93), 4'h4, 1'b0);
    writeOp(11, 1'b0, 1'b1, '1, genData(11, 94), 4'h8);
    idle(1'b0);
    readCheck(7, "R9 write while asleep ignored");
    readCheck(8, "R10 release cycle ignored");
    readCheck(9, "R10 recovery cycle 1 ignored");
    readCheck(10, "R10 recovery cycle 2 ignored");
    readCheck(11, "R10 first open cycle accepted");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule